// File: doc/BRIEF.md
# Dual-NCO Phase-Coherent Hopping Oscillator

This block is the oscillator pair that sits in front of one downconverter's mixer. It holds two numerically controlled oscillators. Each has a 48-bit phase accumulator that grows by its own frequency word on every clock, and a 19-bit phase offset. A registered hop selection picks which of the two drives the 19-bit output phase word. The sine/cosine lookup, the mixer and the filters that follow are outside the block.

Both accumulators advance on every cycle, whichever one is selected. When the output hops back to an oscillator, it resumes at the phase that oscillator would have shown if it had been selected the whole time. Frequency words and offsets are written into staging inputs and only take effect on an update strobe. A clear strobe zeroes both accumulators. The hop choice comes from a GPIO pin or from a software bit, and a source-select input picks which one.

Top module: `nco_hop_pair`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe yet applied, `phase_o` is 0, both accumulators are 0 and NCO 0 is selected.
- R2: After every rising edge on which the clear strobe is low, each accumulator equals its previous value plus its active frequency word, modulo 2^48.
- R3: `phase_o` equals bits [47:29] of the selected accumulator plus the active offset of that NCO, modulo 2^19. It is combinational from registered state.
- R4: Values on `fcw0_i`, `fcw1_i`, `poff0_i` and `poff1_i` have no effect unless `upd_i` is high at a rising edge. On that edge they become the active words.
- R5: A rising edge with `acc_clr_i` high leaves both accumulators at 0.
- R6: When `acc_clr_i` and `upd_i` are high on the same edge, both accumulators become 0 and the new words become active. On the next edge each accumulator equals its new frequency word.
- R7: `hop_src_i` = 0 takes the selection from `hop_gpio_i`, and `hop_src_i` = 1 takes it from `hop_sw_i`. The value 0 selects NCO 0 and the value 1 selects NCO 1.
- R8: The selection is registered, so `phase_o` follows a changed selection input after the next rising edge.
- R9: Both accumulators advance whether or not they are selected. After any sequence of hops, `phase_o` matches a model in which neither accumulator ever pauses.
- R10: With `hop_mode_i` = 1 (coherent) the selection follows the chosen source. With `hop_mode_i` = 0 the registered selection holds its value and both selection inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fcw0_i | input | 48 | Staged frequency word, NCO 0 |
| fcw1_i | input | 48 | Staged frequency word, NCO 1 |
| poff0_i | input | 19 | Staged phase offset, NCO 0 |
| poff1_i | input | 19 | Staged phase offset, NCO 1 |
| hop_gpio_i | input | 1 | Hop selection from pin |
| hop_sw_i | input | 1 | Hop selection from software bit |
| hop_src_i | input | 1 | 0: pin source, 1: software source |
| hop_mode_i | input | 1 | 1: coherent hopping, 0: selection frozen |
| acc_clr_i | input | 1 | Clears both accumulators |
| upd_i | input | 1 | Loads the staged words into the active set |
| phase_o | output | 19 | Output phase of the selected NCO |

## Verification
Every result becomes visible after one rising edge. An accumulator step, a clear, an update and a selection change all land in registers on the edge that samples them, and `phase_o` is computed combinationally from those registers. The bench advances an arithmetic model on each rising edge, using the same input values that the design samples there. It compares `phase_o` with the model on every falling edge. Because inputs also change on the falling edge, `phase_o` never depends on the current inputs when it is compared. The reset synchronizer adds two cycles after reset release, and the bench keeps all strobes quiet during that time.

// File: rtl/nco_hop_pkg.sv
package nco_hop_pkg;

  localparam int unsigned NCO_FCW_W = 48;
  localparam int unsigned NCO_PH_W  = 19;
  localparam int unsigned NCO_COUNT = 2;

  typedef enum logic {
    HOP_SRC_PIN = 1'b0,
    HOP_SRC_SW  = 1'b1
  } hop_src_e;

  typedef enum logic {
    HOP_MODE_FROZEN   = 1'b0,
    HOP_MODE_COHERENT = 1'b1
  } hop_mode_e;

endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/nco_cfg_stage.sv
module nco_cfg_stage #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (load_i) begin
      val_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else begin
      val_q <= val_d;
    end
  end

  assign q_o = val_q;

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned FCW_W = 48,
  parameter int unsigned PH_W  = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [FCW_W-1:0] fcw_i,
  output logic [PH_W-1:0]  top_o
);

  localparam int unsigned TOP_LSB = FCW_W - PH_W;

  logic [FCW_W-1:0] acc_q;
  logic [FCW_W-1:0] acc_d;

  always_comb begin
    if (clr_i) begin
      acc_d = '0;
    end else begin
      acc_d = acc_q + fcw_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign top_o = acc_q[FCW_W-1:TOP_LSB];

endmodule

// File: rtl/nco_hop_ctrl.sv
module nco_hop_ctrl
  import nco_hop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic src_i,
  input  logic pin_sel_i,
  input  logic sw_sel_i,
  output logic sel_o
);

  hop_mode_e mode;
  hop_src_e  src;
  logic      sel_q;
  logic      sel_d;

  assign mode = hop_mode_e'(mode_i);
  assign src  = hop_src_e'(src_i);

  always_comb begin
    sel_d = sel_q;
    if (mode == HOP_MODE_COHERENT) begin
      sel_d = (src == HOP_SRC_SW) ? sw_sel_i : pin_sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/nco_hop_pair.sv
module nco_hop_pair
  import nco_hop_pkg::*;
#(
  parameter int unsigned FCW_W = NCO_FCW_W,
  parameter int unsigned PH_W  = NCO_PH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FCW_W-1:0] fcw0_i,
  input  logic [FCW_W-1:0] fcw1_i,
  input  logic [PH_W-1:0]  poff0_i,
  input  logic [PH_W-1:0]  poff1_i,
  input  logic             hop_gpio_i,
  input  logic             hop_sw_i,
  input  logic             hop_src_i,
  input  logic             hop_mode_i,
  input  logic             acc_clr_i,
  input  logic             upd_i,
  output logic [PH_W-1:0]  phase_o
);

  localparam int unsigned N = NCO_COUNT;

  logic                      rst_n_s;
  logic [N-1:0][FCW_W-1:0]   fcw_stage;
  logic [N-1:0][PH_W-1:0]    poff_stage;
  logic [N-1:0][FCW_W-1:0]   fcw_act;
  logic [N-1:0][PH_W-1:0]    poff_act;
  logic [N-1:0][PH_W-1:0]    acc_top;
  logic                      hop_sel_q;

  assign fcw_stage[0]  = fcw0_i;
  assign fcw_stage[1]  = fcw1_i;
  assign poff_stage[0] = poff0_i;
  assign poff_stage[1] = poff1_i;

  nco_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  for (genvar k = 0; k < N; k++) begin : g_nco
    nco_cfg_stage #(.W(FCW_W)) u_fcw (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .load_i (upd_i),
      .d_i    (fcw_stage[k]),
      .q_o    (fcw_act[k])
    );

    nco_cfg_stage #(.W(PH_W)) u_poff (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .load_i (upd_i),
      .d_i    (poff_stage[k]),
      .q_o    (poff_act[k])
    );

    nco_phase_acc #(.FCW_W(FCW_W), .PH_W(PH_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n_s),
      .clr_i (acc_clr_i),
      .fcw_i (fcw_act[k]),
      .top_o (acc_top[k])
    );
  end

  nco_hop_ctrl u_hop (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mode_i    (hop_mode_i),
    .src_i     (hop_src_i),
    .pin_sel_i (hop_gpio_i),
    .sw_sel_i  (hop_sw_i),
    .sel_o     (hop_sel_q)
  );

  always_comb begin
    phase_o = acc_top[hop_sel_q] + poff_act[hop_sel_q];
  end

endmodule

// File: rtl/nco_hop_pair_chk.sv
module nco_hop_pair_chk #(
  parameter int unsigned FCW_W = 48,
  parameter int unsigned PH_W  = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_clr_i,
  input logic             upd_i,
  input logic             hop_mode_i,
  input logic             hop_src_i,
  input logic             hop_sw_i,
  input logic             hop_gpio_i,
  input logic [FCW_W-1:0] fcw0_i,
  input logic [FCW_W-1:0] fcw0_act,
  input logic [FCW_W-1:0] fcw1_act,
  input logic [PH_W-1:0]  acc0_top,
  input logic [PH_W-1:0]  acc1_top,
  input logic             sel
);

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr_i |=> (acc0_top == '0 && acc1_top == '0));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> ($stable(fcw0_act) && $stable(fcw1_act)));

  // R6
  clr_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr_i && upd_i) |=> (fcw0_act == $past(fcw0_i) && acc0_top == '0));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hop_mode_i |=> $stable(sel));

  // R7
  sw_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_mode_i && hop_src_i) |=> (sel == $past(hop_sw_i)));

  // R8
  pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_mode_i && !hop_src_i) |=> (sel == $past(hop_gpio_i)));

endmodule

bind nco_hop_pair nco_hop_pair_chk #(.FCW_W(FCW_W), .PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .acc_clr_i  (acc_clr_i),
  .upd_i      (upd_i),
  .hop_mode_i (hop_mode_i),
  .hop_src_i  (hop_src_i),
  .hop_sw_i   (hop_sw_i),
  .hop_gpio_i (hop_gpio_i),
  .fcw0_i     (fcw0_i),
  .fcw0_act   (fcw_act[0]),
  .fcw1_act   (fcw_act[1]),
  .acc0_top   (acc_top[0]),
  .acc1_top   (acc_top[1]),
  .sel        (hop_sel_q)
);

// File: tb/nco_hop_pair_test.sv
module nco_hop_pair_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] fcw0_i, fcw1_i;
  logic [18:0] poff0_i, poff1_i;
  logic        hop_gpio_i, hop_sw_i, hop_src_i, hop_mode_i;
  logic        acc_clr_i, upd_i;
  logic [18:0] phase_o;

  always #5 clk = ~clk;

  nco_hop_pair uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .fcw0_i     (fcw0_i),
    .fcw1_i     (fcw1_i),
    .poff0_i    (poff0_i),
    .poff1_i    (poff1_i),
    .hop_gpio_i (hop_gpio_i),
    .hop_sw_i   (hop_sw_i),
    .hop_src_i  (hop_src_i),
    .hop_mode_i (hop_mode_i),
    .acc_clr_i  (acc_clr_i),
    .upd_i      (upd_i),
    .phase_o    (phase_o)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    running = 1'b0;
  bit    done    = 1'b0;
  string tag     = "R1";

  logic [47:0] m_acc0, m_acc1, m_fcw0, m_fcw1;
  logic [18:0] m_poff0, m_poff1;
  logic        m_sel;

  // Reference model, advanced on the same edge the design samples
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc0 = '0; m_acc1 = '0; m_fcw0 = '0; m_fcw1 = '0;
      m_poff0 = '0; m_poff1 = '0; m_sel = 1'b0;
    end else begin
      if (acc_clr_i) begin
        m_acc0 = '0; m_acc1 = '0;
      end else begin
        m_acc0 = m_acc0 + m_fcw0;
        m_acc1 = m_acc1 + m_fcw1;
      end
      if (upd_i) begin
        m_fcw0 = fcw0_i; m_fcw1 = fcw1_i;
        m_poff0 = poff0_i; m_poff1 = poff1_i;
      end
      if (hop_mode_i) m_sel = hop_src_i ? hop_sw_i : hop_gpio_i;
    end
  end

  function automatic logic [18:0] expect_phase();
    if (m_sel) return m_acc1[47:29] + m_poff1;
    else       return m_acc0[47:29] + m_poff0;
  endfunction

  task automatic check(string req, logic [18:0] got, logic [18:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s phase_o=%h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) check(tag, phase_o, expect_phase());
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_update();
    upd_i = 1'b1; cycles(1); upd_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    fcw0_i = '0; fcw1_i = '0; poff0_i = '0; poff1_i = '0;
    hop_gpio_i = 0; hop_sw_i = 0; hop_src_i = 0; hop_mode_i = 0;
    acc_clr_i = 0; upd_i = 0;
    running = 1'b1;
    tag = "R1 reset";
    cycles(3);
    rst_n = 1'b1;
    cycles(4);

    tag = "R4 staged words ignored without update";
    fcw0_i = 48'h1234_5678_9ABC; fcw1_i = 48'h0FED_CBA9_8765;
    poff0_i = 19'h1_2345; poff1_i = 19'h5_4321;
    cycles(6);

    tag = "R6 clear with update";
    acc_clr_i = 1'b1; upd_i = 1'b1; cycles(1);
    acc_clr_i = 1'b0; upd_i = 1'b0;
    cycles(8);

    tag = "R2 R3 sweep of words and offsets";
    hop_mode_i = 1'b1; hop_src_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      fcw0_i  = 48'h0000_3000_0000 * (i + 1) + 48'h0000_0000_1357 * i;
      fcw1_i  = 48'hFFFF_FFFF_FFFF - 48'h0007_0000_0000 * i;
      poff0_i = 19'h7_FFFF - 19'h0_9999 * i;
      poff1_i = 19'h0_4444 * i;
      pulse_update();
      hop_sw_i = i[0];
      cycles(20);
      hop_sw_i = ~i[0];
      cycles(20);
    end

    tag = "R7 R8 R10 selection sweep";
    for (int c = 0; c < 32; c++) begin
      {hop_mode_i, hop_src_i, hop_gpio_i, hop_sw_i} = 4'(c ^ (c >> 1));
      cycles(5);
    end

    tag = "R9 return after hop";
    hop_mode_i = 1'b1; hop_src_i = 1'b0; hop_gpio_i = 1'b0;
    cycles(10);
    hop_gpio_i = 1'b1; cycles(37);
    hop_gpio_i = 1'b0; cycles(12);
    hop_gpio_i = 1'b1; cycles(3);
    hop_gpio_i = 1'b0; cycles(5);

    tag = "R5 clear mid-run";
    acc_clr_i = 1'b1; cycles(1); acc_clr_i = 1'b0;
    cycles(10);
    acc_clr_i = 1'b1; cycles(3); acc_clr_i = 1'b0;
    hop_gpio_i = 1'b1; cycles(10);

    tag = "R4 staged change mid-run ignored";
    fcw0_i = 48'h5555_5555_5555; fcw1_i = 48'h0000_0000_0001;
    poff0_i = 19'h0_0001; poff1_i = 19'h2_AAAA;
    cycles(15);

    tag = "R1 reset mid-run";
    rst_n = 1'b0; hop_mode_i = 1'b0; cycles(2);
    rst_n = 1'b1; cycles(4);

    running = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule